// File: doc/BRIEF.md
# Serial Capture-and-Replay Byte Buffer

This block listens on an asynchronous serial receive line, collects each correctly framed byte into a small on-chip array, and then plays the whole collection back, oldest byte first, on an asynchronous serial transmit line. Both directions use one start bit (low), eight data bits with the least significant bit first, no parity and one stop bit (high). With the default parameters it runs from a 50 MHz clock at 9600 baud. The receiver oversamples each bit 16 times.

Operation alternates between two phases. In the capture phase arriving bytes are written to successive array slots. Replay begins when the array is full, or when the receive line has been quiet for a set number of byte times while at least one byte is held. In the replay phase the stored bytes are transmitted back to back. Once the last one has gone out, both pointers return to zero and capture resumes. A single active-high switch input acts as a synchronous reset. While it is high, traffic is stopped and the array is emptied.

Top module: `uart_store_echo`

## Requirements
- R1: While `sw_rst` is high and on the cycle after it, `tx_out` is high (idle line).
- R2: Each transmitted frame is a low start bit, eight data bits with bit 0 first, and a high stop bit. Each bit lasts OVERSAMPLE ticks, and one tick is CLK_HZ/(BAUD*OVERSAMPLE) clocks. A new frame starts only when the transmitter is free.
- R3: When DEPTH bytes have been stored, replay starts and the DEPTH bytes are sent in the order they arrived.
- R4: With at least one byte stored, IDLE_BYTES*10 bit times of receive inactivity start replay of exactly the stored bytes, in order.
- R5: A received frame whose stop bit samples low is discarded and not stored.
- R6: A low pulse on `rx_in` that ends before the middle of the start bit does not produce a byte.
- R7: Bytes that complete while replay is running are not stored.
- R8: After the last stored byte is sent, the block returns to capture with an empty array. The next replay holds only bytes received after that point.
- R9: Asserting `sw_rst` during capture discards all bytes stored so far.
- R10: Receive inactivity with an empty array never starts a replay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| sw_rst | input | 1 | Synchronous active-high reset from a switch; disables traffic and empties the array |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| tx_out | output | 1 | Serial transmit line, idle high |

## Verification
The bound checker watches five things on every cycle: pointer ordering and bounds, the rule that a frame starts only on a free transmitter, the frozen write pointer during replay, the empty array on return to capture, and the idle level after reset. Whether the bytes come back with the right values and in the right order can only be shown by the bench. The same holds for the rejection of bad stop bits and short start glitches, the idle timeout trigger, and the loss of data on reset. The bench shows these by decoding the transmit line over whole sessions of traffic.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE, TX_START, TX_DATA, TX_STOP
    } tx_state_t;

    typedef enum logic {
        PH_CAPTURE, PH_REPLAY
    } phase_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } rx_byte_t;

    localparam int unsigned FRAME_BITS = 10;

    function automatic int unsigned tick_divider(int unsigned clk_hz, int unsigned baud,
                                                 int unsigned ovs);
        int unsigned d;
        d = clk_hz / (baud * ovs);
        return (d == 0) ? 1 : d;
    endfunction

endpackage

// File: rtl/echo_tick.sv
module echo_tick #(
    parameter int unsigned DIV = 325
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    assign tick = (cnt == W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/echo_rx.sv
module echo_rx
    import uart_echo_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx_in,
    output rx_byte_t rx_out,
    output logic     rx_idle
);
    localparam int unsigned CW = $clog2(OVS);

    rx_state_t   st;
    logic [1:0]  sync;
    logic        rx_s;
    logic [CW-1:0] cnt;
    logic [2:0]  bidx;
    logic [7:0]  shreg;

    assign rx_s    = sync[1];
    assign rx_idle = (st == RX_IDLE) && rx_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync   <= 2'b11;
            st     <= RX_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            shreg  <= '0;
            rx_out <= '0;
        end else begin
            sync         <= {sync[0], rx_in};
            rx_out.valid <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (!rx_s) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt == CW'(OVS / 2 - 1)) begin
                            cnt <= '0;
                            if (!rx_s) begin
                                st   <= RX_DATA;
                                bidx <= '0;
                            end else begin
                                st <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt   <= '0;
                            shreg <= {rx_s, shreg[7:1]};
                            if (bidx == 3'd7) st <= RX_STOP;
                            else              bidx <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt <= '0;
                            if (rx_s) begin
                                rx_out.valid <= 1'b1;
                                rx_out.data  <= shreg;
                                st           <= RX_IDLE;
                            end else begin
                                st <= RX_WAIT_HIGH;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_WAIT_HIGH: if (rx_s) st <= RX_IDLE;
                default:      st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/echo_tx.sv
module echo_tx
    import uart_echo_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       go,
    input  logic [7:0] data,
    output logic       tx_out,
    output logic       busy
);
    localparam int unsigned CW = $clog2(OVS);

    tx_state_t     st;
    logic [CW-1:0] cnt;
    logic [2:0]    bidx;
    logic [7:0]    shreg;
    logic          bit_end;

    assign busy    = (st != TX_IDLE);
    assign bit_end = tick && (cnt == CW'(OVS - 1));

    always_comb begin
        case (st)
            TX_START: tx_out = 1'b0;
            TX_DATA:  tx_out = shreg[0];
            default:  tx_out = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= TX_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            shreg <= '0;
        end else begin
            if (st != TX_IDLE && tick) cnt <= bit_end ? '0 : cnt + 1'b1;
            case (st)
                TX_IDLE: begin
                    if (go) begin
                        shreg <= data;
                        cnt   <= '0;
                        st    <= TX_START;
                    end
                end
                TX_START: begin
                    if (bit_end) begin
                        st   <= TX_DATA;
                        bidx <= '0;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        shreg <= {1'b1, shreg[7:1]};
                        if (bidx == 3'd7) st <= TX_STOP;
                        else              bidx <= bidx + 1'b1;
                    end
                end
                TX_STOP:  if (bit_end) st <= TX_IDLE;
                default:  st <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/echo_store.sv
module echo_store
    import uart_echo_pkg::*;
#(
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned IDLE_TICKS = 1600,
    localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  rx_byte_t      rx_byte,
    input  logic          rx_idle,
    input  logic          tx_busy,
    output logic          tx_go,
    output logic [7:0]    tx_data,
    output phase_t        phase,
    output logic [CW-1:0] wr_cnt,
    output logic [CW-1:0] rd_cnt
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned IW = $clog2(IDLE_TICKS + 1);
    localparam logic [CW-1:0] FULL  = CW'(DEPTH);
    localparam logic [IW-1:0] LIMIT = IW'(IDLE_TICKS);

    logic [7:0]    mem [DEPTH];
    logic [IW-1:0] idle_cnt;
    logic          wr_en;
    logic          start_replay;

    assign wr_en        = (phase == PH_CAPTURE) && rx_byte.valid && (wr_cnt < FULL);
    assign start_replay = (wr_cnt == FULL) || ((idle_cnt == LIMIT) && (wr_cnt != '0));
    assign tx_go        = (phase == PH_REPLAY) && !tx_busy && (rd_cnt < wr_cnt);
    assign tx_data      = mem[rd_cnt[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_cnt[AW-1:0]] <= rx_byte.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_CAPTURE;
            wr_cnt   <= '0;
            rd_cnt   <= '0;
            idle_cnt <= '0;
        end else begin
            case (phase)
                PH_CAPTURE: begin
                    if (wr_en) begin
                        wr_cnt   <= wr_cnt + 1'b1;
                        idle_cnt <= '0;
                    end else if (!rx_idle) begin
                        idle_cnt <= '0;
                    end else if (tick && idle_cnt != LIMIT) begin
                        idle_cnt <= idle_cnt + 1'b1;
                    end
                    if (start_replay) begin
                        phase    <= PH_REPLAY;
                        rd_cnt   <= '0;
                        idle_cnt <= '0;
                    end
                end
                default: begin
                    if (tx_go) begin
                        rd_cnt <= rd_cnt + 1'b1;
                    end else if (!tx_busy && rd_cnt == wr_cnt) begin
                        phase  <= PH_CAPTURE;
                        wr_cnt <= '0;
                        rd_cnt <= '0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_store_echo.sv
module uart_store_echo
    import uart_echo_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned BAUD       = 9600,
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned IDLE_BYTES = 10
) (
    input  logic clk,
    input  logic sw_rst,
    input  logic rx_in,
    output logic tx_out
);
    localparam int unsigned DIV        = tick_divider(CLK_HZ, BAUD, OVERSAMPLE);
    localparam int unsigned IDLE_TICKS = IDLE_BYTES * FRAME_BITS * OVERSAMPLE;
    localparam int unsigned CW         = $clog2(DEPTH + 1);

    logic          tick;
    rx_byte_t      rx_byte;
    logic          rx_idle;
    logic          tx_go;
    logic          tx_busy;
    logic [7:0]    tx_data;
    phase_t        phase;
    logic [CW-1:0] wr_cnt;
    logic [CW-1:0] rd_cnt;

    echo_tick #(.DIV(DIV)) u_tick (
        .clk (clk),
        .rst (sw_rst),
        .tick(tick)
    );

    echo_rx #(.OVS(OVERSAMPLE)) u_rx (
        .clk    (clk),
        .rst    (sw_rst),
        .tick   (tick),
        .rx_in  (rx_in),
        .rx_out (rx_byte),
        .rx_idle(rx_idle)
    );

    echo_store #(.DEPTH(DEPTH), .IDLE_TICKS(IDLE_TICKS)) u_store (
        .clk    (clk),
        .rst    (sw_rst),
        .tick   (tick),
        .rx_byte(rx_byte),
        .rx_idle(rx_idle),
        .tx_busy(tx_busy),
        .tx_go  (tx_go),
        .tx_data(tx_data),
        .phase  (phase),
        .wr_cnt (wr_cnt),
        .rd_cnt (rd_cnt)
    );

    echo_tx #(.OVS(OVERSAMPLE)) u_tx (
        .clk   (clk),
        .rst   (sw_rst),
        .tick  (tick),
        .go    (tx_go),
        .data  (tx_data),
        .tx_out(tx_out),
        .busy  (tx_busy)
    );
endmodule

// File: rtl/uart_store_echo_chk.sv
module uart_store_echo_chk
    import uart_echo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          sw_rst,
    input logic          tx_out,
    input phase_t        phase,
    input logic [CW-1:0] wr_cnt,
    input logic [CW-1:0] rd_cnt,
    input logic          tx_busy,
    input logic          tx_go,
    input logic          rx_valid
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    // R1: line idles high right after reset
    a_r1_idle_after_reset: assert property (@(posedge clk)
        sw_rst |=> tx_out);

    // R2: a frame is launched only into a free transmitter, which then turns busy
    a_r2_go_when_free: assert property (@(posedge clk) disable iff (sw_rst)
        tx_go |-> !tx_busy);
    a_r2_busy_after_go: assert property (@(posedge clk) disable iff (sw_rst)
        tx_go |=> tx_busy);

    // R3: pointers stay ordered and bounded
    a_r3_ptr_order: assert property (@(posedge clk) disable iff (sw_rst)
        (rd_cnt <= wr_cnt) && (wr_cnt <= FULL));

    // R7: no write while replaying
    a_r7_no_store_in_replay: assert property (@(posedge clk) disable iff (sw_rst)
        (phase == PH_REPLAY && rx_valid) |=> (wr_cnt == $past(wr_cnt)) || (wr_cnt == '0));

    // R8: back in capture with an empty array
    a_r8_empty_on_return: assert property (@(posedge clk) disable iff (sw_rst)
        (phase == PH_REPLAY) |=> (phase == PH_REPLAY) || (wr_cnt == '0 && rd_cnt == '0));
endmodule

bind uart_store_echo uart_store_echo_chk #(.DEPTH(DEPTH)) i_chk (
    .clk     (clk),
    .sw_rst  (sw_rst),
    .tx_out  (tx_out),
    .phase   (phase),
    .wr_cnt  (wr_cnt),
    .rd_cnt  (rd_cnt),
    .tx_busy (tx_busy),
    .tx_go   (tx_go),
    .rx_valid(rx_byte.valid)
);

// File: tb/test_uart_store_echo.sv
`timescale 1ns/1ps
module test_uart_store_echo;
    // small configuration: 10 clocks per tick, 160 clocks per bit
    localparam int unsigned CLK_HZ  = 1_600_000;
    localparam int unsigned BAUD    = 10_000;
    localparam int unsigned OVS     = 16;
    localparam int unsigned DEPTH   = 4;
    localparam int unsigned IDLE_B  = 3;
    localparam int BIT_CLK  = CLK_HZ / BAUD;
    localparam int BIT_NS   = BIT_CLK * 10;
    localparam int FRAME_NS = BIT_NS * 10;
    localparam int IDLE_NS  = IDLE_B * FRAME_NS;

    logic clk = 1'b0;
    logic sw_rst = 1'b1;
    logic rx_in = 1'b1;
    logic tx_out;

    int n_chk = 0;
    int n_err = 0;
    int n_log = 0;
    int frame_err = 0;
    logic [7:0] log_q [128];
    logic [7:0] exp_q [16];
    int exp_n = 0;

    always #5 clk = ~clk;

    uart_store_echo #(
        .CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVERSAMPLE(OVS),
        .DEPTH(DEPTH), .IDLE_BYTES(IDLE_B)
    ) i_uart_store_echo (
        .clk(clk), .sw_rst(sw_rst), .rx_in(rx_in), .tx_out(tx_out)
    );

    // transmit-line decoder
    initial begin
        forever begin
            logic [7:0] b;
            @(negedge tx_out);
            #(BIT_NS / 2 + 3);
            if (tx_out !== 1'b0) frame_err++;
            b = '0;
            for (int i = 0; i < 8; i++) begin
                #(BIT_NS);
                b[i] = tx_out;
            end
            #(BIT_NS);
            if (tx_out !== 1'b1) frame_err++;
            if (n_log < 128) log_q[n_log] = b;
            n_log++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic v);
        rx_in = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit good_stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        send_bit(good_stop);
        if (!good_stop) send_bit(1'b1);
    endtask

    task automatic pulse_reset();
        sw_rst = 1'b1;
        repeat (5) @(negedge clk);
        sw_rst = 1'b0;
    endtask

    // waits for exp_n decoded bytes after base, then compares
    task automatic check_session(input string req, input int base);
        int waited;
        waited = 0;
        while (n_log < base + exp_n && waited < IDLE_NS + exp_n * FRAME_NS + 40000) begin
            #1000;
            waited += 1000;
        end
        #20000;
        chk(n_log - base == exp_n, req, n_log - base, exp_n);
        for (int i = 0; i < exp_n; i++)
            chk(log_q[base + i] == exp_q[i], req, log_q[base + i], exp_q[i]);
    endtask

    initial begin
        #1_950_000;
        n_err++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        chk(tx_out === 1'b1, "R1 idle during reset", tx_out, 1);
        pulse_reset();
        chk(tx_out === 1'b1, "R1 idle after reset", tx_out, 1);

        // R10: quiet line with nothing stored
        #60000;
        chk(n_log == 0, "R10 no replay when empty", n_log, 0);

        // R3: fill the array, replay in order
        base = n_log;
        exp_q[0] = 8'hA1; exp_q[1] = 8'hB2; exp_q[2] = 8'hC3; exp_q[3] = 8'hD4; exp_n = 4;
        for (int i = 0; i < 4; i++) send_frame(exp_q[i], 1'b1);
        check_session("R3 full replay", base);
        chk(frame_err == 0, "R2 framing", frame_err, 0);

        // R4 + R5: partial fill with a bad-stop frame in between
        base = n_log;
        send_frame(8'h55, 1'b1);
        send_frame(8'h77, 1'b0);
        send_frame(8'h66, 1'b1);
        exp_q[0] = 8'h55; exp_q[1] = 8'h66; exp_n = 2;
        check_session("R4 R5 idle replay without bad frame", base);

        // R6: short glitch then one byte
        base = n_log;
        rx_in = 1'b0;
        repeat (BIT_CLK / 4) @(negedge clk);
        rx_in = 1'b1;
        repeat (BIT_CLK * 2) @(negedge clk);
        send_frame(8'h3C, 1'b1);
        exp_q[0] = 8'h3C; exp_n = 1;
        check_session("R6 glitch rejected", base);

        // R7: byte during replay is dropped
        base = n_log;
        exp_q[0] = 8'h10; exp_q[1] = 8'h20; exp_q[2] = 8'h30; exp_q[3] = 8'h40; exp_n = 4;
        for (int i = 0; i < 4; i++) send_frame(exp_q[i], 1'b1);
        send_frame(8'hEE, 1'b1);
        check_session("R7 replay content", base);
        // R8: next session holds only the new byte
        base = n_log;
        send_frame(8'h5A, 1'b1);
        exp_q[0] = 8'h5A; exp_n = 1;
        check_session("R7 R8 fresh capture", base);

        // R9: reset mid-capture
        base = n_log;
        send_frame(8'h81, 1'b1);
        send_frame(8'h82, 1'b1);
        pulse_reset();
        chk(tx_out === 1'b1, "R1 idle after second reset", tx_out, 1);
        exp_n = 0;
        check_session("R9 stored bytes discarded", base);
        base = n_log;
        send_frame(8'h99, 1'b1);
        exp_q[0] = 8'h99; exp_n = 1;
        check_session("R9 capture after reset", base);

        // R3 sweep: four full sessions with computed values
        for (int s = 0; s < 4; s++) begin
            base = n_log;
            exp_n = 4;
            for (int i = 0; i < 4; i++) begin
                exp_q[i] = 8'(((s * 4 + i) * 37 + 11) ^ (s * 64));
                send_frame(exp_q[i], 1'b1);
            end
            check_session("R3 sweep", base);
        end
        chk(frame_err == 0, "R2 framing overall", frame_err, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule